// File: doc/BRIEF.md
# Pseudo-SRAM Start-Up and Deep-Sleep Sequencer

This block brings a pseudo-static RAM from power-on to a usable state. It also takes the memory into and out of its deepest low-power state, in which memory contents are lost. After power is reported good, the sequencer holds chip select and the mode pin high for a long settling wait. It then issues a fixed number of dummy reads, each a separate chip-select low pulse with output enable held high. Only then does it hand the memory pins to the access controller and raise `ready`.

While `ready` is high, chip select and output enable are passed through from the access controller. A sleep request is taken only when the controller reports idle. When taken, `ready` drops, chip select is held high for one cycle, and then the mode pin goes low. A wake request in deep standby repeats the whole start-up sequence. Loss of power-good returns the block to its initial state from anywhere.

The FSM has these states: OFF (initial, power not good), WAIT (settling count), RD_LOW (dummy-read pulse), RD_GAP (high gap between pulses), ACTIVE (pins granted), ENTER (chip select high before mode drops) and DEEP (data-losing standby). Its transitions are:
- OFF->WAIT on power good.
- WAIT->RD_LOW when the wait count expires.
- RD_LOW->RD_GAP, or RD_LOW->ACTIVE after the last read.
- RD_GAP->RD_LOW.
- ACTIVE->ENTER on an accepted sleep request.
- ENTER->DEEP unconditionally.
- DEEP->WAIT on wake.
- Any state->OFF on loss of power good.

Top module: `psram_pwr_seq`

## Requirements
- R1: After reset, and while `pwr_good` stays low, `mem_cs_n`=1, `mem_mode`=1, `mem_oe_n`=1, `ready`=0 and `dummy_rd`=0.
- R2: Once `pwr_good` is sampled high, chip select and mode stay high for exactly WAIT_CYC cycles before the first dummy read.
- R3: Exactly NUM_READS chip-select low pulses follow the wait. Each pulse lasts RD_LOW_CYC cycles, with RD_GAP_CYC high cycles between pulses. `dummy_rd` is 1 exactly during the pulses. `mem_oe_n` is 1 whenever `ready` is 0.
- R4: `ready` rises in the cycle right after the last pulse. While `ready` is 1, `mem_cs_n` equals `ctl_cs_n` and `mem_oe_n` equals `ctl_oe_n`.
- R5: `mem_mode` is 1 in every state except deep standby.
- R6: A sleep request sampled in ACTIVE with `ctl_idle`=1 drops `ready` in the next cycle. Chip select is then high with mode still high for one cycle, after which mode goes low while chip select stays high.
- R7: A sleep request while `ctl_idle`=0 has no effect: `ready` stays 1.
- R8: `wake_req` outside deep standby has no effect. In particular it does not disturb ACTIVE or the start-up count.
- R9: `wake_req` in deep standby raises mode and repeats the full wait and dummy-read sequence before `ready` returns.
- R10: `pwr_good` sampled low in any state returns the block to the R1 outputs in the next cycle. The full sequence restarts when power is good again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply stable indication |
| sleep_req | input | 1 | Request for data-losing standby |
| wake_req | input | 1 | Request to leave deep standby |
| ctl_idle | input | 1 | Access controller has no access in flight |
| ctl_cs_n | input | 1 | Chip select from access controller |
| ctl_oe_n | input | 1 | Output enable from access controller |
| mem_cs_n | output | 1 | Chip select to memory, active low |
| mem_mode | output | 1 | Mode pin to memory, low only in deep standby |
| mem_oe_n | output | 1 | Output enable to memory, active low |
| dummy_rd | output | 1 | High during each start-up dummy-read pulse |
| ready | output | 1 | Pins granted to access controller |

## Verification
On every cycle, the assertions check these properties:
- The mode pin is never low unless chip select is high, and it only falls after a cycle with chip select high.
- Output enable stays inactive while the pins are not granted.
- `ready` only rises straight after a dummy-read pulse, and it holds unless power drops or an idle sleep request arrives.
- Power loss always returns the pins to the initial levels.

The exact length of the wait, the count and width of the dummy-read pulses, and the full restart after wake or power loss are shown only by the bench scenarios. These scenarios compare each cycle against a phase model while the ignored inputs are randomized.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

    typedef enum logic [2:0] {
        SQ_OFF    = 3'd0,
        SQ_WAIT   = 3'd1,
        SQ_RD_LOW = 3'd2,
        SQ_RD_GAP = 3'd3,
        SQ_ACTIVE = 3'd4,
        SQ_ENTER  = 3'd5,
        SQ_DEEP   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/psram_phase_timer.sv
module psram_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // phase length counts down by one per cycle
    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/psram_read_counter.sv
module psram_read_counter #(
    parameter int NUM_READS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int RW = (NUM_READS > 1) ? $clog2(NUM_READS) : 1;
    localparam logic [RW-1:0] LAST_IDX = RW'(NUM_READS - 1);

    logic [RW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_IDX);

    // never counts beyond the number of dummy reads
    assert_read_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt < LAST_IDX));
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
    parameter int WAIT_CYC   = 10000,
    parameter int RD_LOW_CYC = 5,
    parameter int RD_GAP_CYC = 2,
    parameter int NUM_READS  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic sleep_req,
    input  logic wake_req,
    input  logic ctl_idle,
    input  logic ctl_cs_n,
    input  logic ctl_oe_n,
    output logic mem_cs_n,
    output logic mem_mode,
    output logic mem_oe_n,
    output logic dummy_rd,
    output logic ready
);
    import psram_seq_pkg::*;

    localparam int LEN_A   = (WAIT_CYC > RD_LOW_CYC) ? WAIT_CYC : RD_LOW_CYC;
    localparam int LEN_MAX = (LEN_A > RD_GAP_CYC) ? LEN_A : RD_GAP_CYC;
    localparam int CW      = $clog2(LEN_MAX + 1);

    seq_state_e    state, state_n;
    logic          t_load, t_done, rd_last;
    logic [CW-1:0] t_len;

    psram_phase_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .len   (t_len),
        .done  (t_done)
    );

    psram_read_counter #(.NUM_READS(NUM_READS)) u_reads (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_n == SQ_WAIT && state != SQ_WAIT),
        .inc   (state == SQ_RD_LOW && state_n == SQ_RD_GAP),
        .last  (rd_last)
    );

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            SQ_OFF:    if (pwr_good) state_n = SQ_WAIT;
            SQ_WAIT:   if (t_done) state_n = SQ_RD_LOW;
            SQ_RD_LOW: if (t_done) state_n = rd_last ? SQ_ACTIVE : SQ_RD_GAP;
            SQ_RD_GAP: if (t_done) state_n = SQ_RD_LOW;
            SQ_ACTIVE: if (sleep_req && ctl_idle) state_n = SQ_ENTER;
            SQ_ENTER:  state_n = SQ_DEEP;
            SQ_DEEP:   if (wake_req) state_n = SQ_WAIT;
            default:   state_n = SQ_OFF;
        endcase
        if (!pwr_good)
            state_n = SQ_OFF;
    end

    always_comb begin
        t_load = (state_n != state);
        unique case (state_n)
            SQ_WAIT:   t_len = CW'(WAIT_CYC);
            SQ_RD_LOW: t_len = CW'(RD_LOW_CYC);
            default:   t_len = CW'(RD_GAP_CYC);
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SQ_OFF;
        else
            state <= state_n;
    end

    // outputs
    always_comb begin
        mem_cs_n = 1'b1;
        mem_mode = 1'b1;
        mem_oe_n = 1'b1;
        dummy_rd = 1'b0;
        ready    = 1'b0;
        unique case (state)
            SQ_RD_LOW: begin
                mem_cs_n = 1'b0;
                dummy_rd = 1'b1;
            end
            SQ_ACTIVE: begin
                mem_cs_n = ctl_cs_n;
                mem_oe_n = ctl_oe_n;
                ready    = 1'b1;
            end
            SQ_DEEP:  mem_mode = 1'b0;
            default: ;
        endcase
    end

    assert_deep_cs_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_mode |-> mem_cs_n);

    assert_mode_fall_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_mode) |-> ($past(mem_cs_n) && $past(!ready)));

    assert_oe_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> mem_oe_n);

    assert_ready_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(dummy_rd));

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pwr_good && !(sleep_req && ctl_idle)) |=> ready);

    assert_pwr_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!ready && mem_cs_n && mem_mode && !dummy_rd));
endmodule

// File: tb/psram_pwr_seq_bench.sv
module psram_pwr_seq_bench;
    localparam int W = 20;
    localparam int L = 3;
    localparam int G = 2;
    localparam int N = 3;
    localparam int SEQ = N * L + (N - 1) * G;
    localparam int TOT = W + SEQ + 1;

    logic clk = 1'b0;
    logic rst_n, pwr_good, sleep_req, wake_req, ctl_idle, ctl_cs_n, ctl_oe_n;
    logic mem_cs_n, mem_mode, mem_oe_n, dummy_rd, ready;
    int   nchk = 0;
    int   nfail = 0;

    always #10 clk = ~clk;

    psram_pwr_seq #(.WAIT_CYC(W), .RD_LOW_CYC(L), .RD_GAP_CYC(G), .NUM_READS(N))
    u_psram_pwr_seq (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sleep_req(sleep_req),
        .wake_req(wake_req), .ctl_idle(ctl_idle), .ctl_cs_n(ctl_cs_n),
        .ctl_oe_n(ctl_oe_n), .mem_cs_n(mem_cs_n), .mem_mode(mem_mode),
        .mem_oe_n(mem_oe_n), .dummy_rd(dummy_rd), .ready(ready)
    );

    // 0: wait or gap, 1: dummy-read pulse, 2: active; k counts samples after trigger
    function automatic int phase_at(int k);
        int j;
        if (k <= W) return 0;
        j = k - W - 1;
        if (j >= SEQ) return 2;
        return ((j % (L + G)) < L) ? 1 : 0;
    endfunction

    task automatic chk(string req, string what, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_idle(string req, logic mode_exp);
        chk(req, "cs_n", mem_cs_n, 1'b1);
        chk(req, "mode", mem_mode, mode_exp);
        chk(req, "oe_n", mem_oe_n, 1'b1);
        chk(req, "ready", ready, 1'b0);
        chk(req, "dummy_rd", dummy_rd, 1'b0);
    endtask

    // trigger (pwr_good or wake) already driven at the last negedge
    task automatic run_startup(string req);
        for (int k = 1; k <= TOT; k++) begin
            int ph;
            @(negedge clk);
            ph = phase_at(k);
            if (ph == 2) begin
                chk("R4", {req, " ready"}, ready, 1'b1);
                chk("R4", {req, " cs pass"}, mem_cs_n, ctl_cs_n);
                chk("R4", {req, " oe pass"}, mem_oe_n, ctl_oe_n);
            end else begin
                chk(ph == 1 ? "R3" : "R2", {req, " cs_n"}, mem_cs_n, ph == 1 ? 1'b0 : 1'b1);
                chk("R3", {req, " dummy_rd"}, dummy_rd, ph == 1);
                chk("R3", {req, " oe_n"}, mem_oe_n, 1'b1);
                chk("R3", {req, " ready"}, ready, 1'b0);
            end
            chk("R5", {req, " mode"}, mem_mode, 1'b1);
            if (k < TOT) begin
                wake_req  = 1'($urandom);   // R8: ignored during start-up
                sleep_req = 1'($urandom);
                ctl_idle  = 1'($urandom);
                ctl_cs_n  = 1'($urandom);
                ctl_oe_n  = 1'($urandom);
            end else begin
                wake_req = 0; sleep_req = 0; ctl_idle = 1; ctl_cs_n = 1; ctl_oe_n = 1;
            end
        end
    endtask

    task automatic run_active(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            chk("R7", "ready hold", ready, 1'b1);
            chk("R4", "cs pass", mem_cs_n, ctl_cs_n);
            chk("R4", "oe pass", mem_oe_n, ctl_oe_n);
            chk("R8", "mode", mem_mode, 1'b1);
            ctl_cs_n  = 1'($urandom);
            ctl_oe_n  = 1'($urandom);
            wake_req  = 1'($urandom);
            sleep_req = 1'($urandom);
            ctl_idle  = 1'b0;
        end
        @(negedge clk);
        chk("R7", "ready hold end", ready, 1'b1);
        wake_req = 0; sleep_req = 0; ctl_idle = 1; ctl_cs_n = 1; ctl_oe_n = 1;
    endtask

    task automatic go_deep();
        sleep_req = 1; ctl_idle = 1; ctl_cs_n = 1; ctl_oe_n = 1;
        @(negedge clk);
        chk_idle("R6", 1'b1);
        sleep_req = 0;
        @(negedge clk);
        chk_idle("R6", 1'b0);
        for (int i = 0; i < 4; i++) begin
            sleep_req = 1'($urandom);
            ctl_idle  = 1'($urandom);
            ctl_cs_n  = 1'($urandom);
            @(negedge clk);
            chk_idle("R6", 1'b0);
        end
        sleep_req = 0; ctl_idle = 1; ctl_cs_n = 1;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd4242);
        rst_n = 0; pwr_good = 0; sleep_req = 0; wake_req = 0;
        ctl_idle = 1; ctl_cs_n = 1; ctl_oe_n = 1;
        repeat (3) @(negedge clk);
        chk_idle("R1", 1'b1);
        rst_n = 1;
        for (int i = 0; i < 5; i++) begin
            wake_req = 1'($urandom);
            sleep_req = 1'($urandom);
            @(negedge clk);
            chk_idle("R1", 1'b1);
        end
        wake_req = 0; sleep_req = 0;
        pwr_good = 1;
        run_startup("R2");

        for (int round = 0; round < 3; round++) begin
            run_active(20);
            go_deep();
            wake_req = 1;
            run_startup("R9");
            run_active(10);
            go_deep();
            pwr_good = 0;
            @(negedge clk);
            chk_idle("R10", 1'b1);
            @(negedge clk);
            chk_idle("R10", 1'b1);
            pwr_good = 1;
            run_startup("R10");
            // power drop in the middle of start-up
            pwr_good = 0;
            @(negedge clk);
            pwr_good = 1;
            repeat (W + 2 + round) @(negedge clk);
            pwr_good = 0;
            @(negedge clk);
            chk_idle("R10", 1'b1);
            pwr_good = 1;
            run_startup("R10");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule